// File: doc/BRIEF.md
# Nine-Sample Majority-Vote Median Finder

This block returns the median of nine unsigned samples, for example one 3×3 pixel neighbourhood, without sorting them. Each captured sample is expanded into a unary thermometer word. At every bit position of those words, a vote is taken across the nine samples. The winning bits together form the thermometer code of the median. A decoder then turns that code back into a binary value.

No column depends on any other column, so the logic depth is the same for any sample width. The sample width is a parameter. A second parameter selects how the thermometer result is decoded. The nine samples arrive as one flat word. They are captured when the input strobe is high, and the median appears one clock later, qualified by its own strobe.

Top module: `median9_vote`

## Requirements
- R1: After a capture, `med_value` equals the fifth smallest of the nine captured samples, and `med_valid` is high.
- R2: A sample v is expanded into a 2^SAMPLE_W-bit word whose v lowest bits are 1 and whose other bits are 0. `med_therm` carries this form of the median. With 4-bit samples, a median of 2 gives 16'h0003 and a median of 8 gives 16'h00FF.
- R3: Bit j of `med_therm` is 1 exactly when at least five of the nine captured samples are greater than j.
- R4: `med_therm` is always a contiguous run of ones starting at bit 0, and its top bit is always 0.
- R5: `med_value` equals the number of ones in `med_therm`.
- R6: When `in_valid` is high at a rising edge, `in_window` is captured, and `med_valid` is high in the following cycle with the median of that window.
- R7: When `in_valid` is low at a rising edge, `in_window` is ignored: `med_valid` is low in the following cycle and `med_value` keeps its previous value.
- R8: A synchronous active-high `rst` clears `med_valid` and the captured window, so `med_value` reads 0 after reset.
- R9: The result does not depend on the order in which the nine samples are placed in `in_window`. Sample k occupies bits [SAMPLE_W*k+SAMPLE_W-1 : SAMPLE_W*k].
- R10: Windows whose samples are all equal, including all 0 and all at the maximum value, return that value. Windows with repeated values at the middle rank return that repeated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the window |
| in_window | input | 9*SAMPLE_W | Nine packed samples, sample k in slice k |
| med_valid | output | 1 | Median of the last captured window is presented |
| med_value | output | SAMPLE_W | Binary median |
| med_therm | output | 2**SAMPLE_W | Thermometer form of the median |

## Verification
Each of two columns is driven through all 512 patterns of nine bits by choosing every sample as either j or j+1. This isolates the vote of column j and compares it with a population count. Fixed windows check the following separately:
- the ascending window and a shuffled copy of it, which tells a true median apart from an order-dependent pick;
- all-equal windows at 0, 8 and 15;
- a window with a repeated middle value.

Random windows with gaps in the strobe are compared on every clock against a behavioural sort. A strobe-low cycle and a mid-stream reset show that the captured value is held or cleared.

// File: rtl/medmaj_pkg.sv
package medmaj_pkg;

    localparam int TAPS = 9;
    localparam int ROWS = 3;

    typedef enum logic {
        DEC_POPCOUNT = 1'b0,
        DEC_PRIORITY = 1'b1
    } dec_style_e;

    typedef struct packed {
        logic lo;
        logic mid;
        logic hi;
    } row_rank_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic and3(input logic a, input logic b, input logic c);
        return maj3(maj3(a, b, 1'b0), c, 1'b0);
    endfunction

    function automatic logic or3(input logic a, input logic b, input logic c);
        return maj3(maj3(a, b, 1'b1), c, 1'b1);
    endfunction

    function automatic row_rank_t rank_row(input logic [2:0] r);
        row_rank_t o;
        o.lo  = and3(r[0], r[1], r[2]);
        o.mid = maj3(r[0], r[1], r[2]);
        o.hi  = or3(r[0], r[1], r[2]);
        return o;
    endfunction

endpackage

// File: rtl/medmaj_therm_enc.sv
module medmaj_therm_enc #(
    parameter int SAMPLE_W = 4,
    localparam int TW = 2 ** SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] value,
    output logic [TW-1:0]       therm
);
    for (genvar j = 0; j < TW; j++) begin : g_bit
        localparam logic [SAMPLE_W:0] THRESH = (SAMPLE_W + 1)'(j);
        assign therm[j] = ({1'b0, value} > THRESH);
    end
endmodule

// File: rtl/medmaj_column_vote.sv
module medmaj_column_vote
    import medmaj_pkg::*;
(
    input  logic [TAPS-1:0] col_bits,
    output logic            vote
);
    row_rank_t rank [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign rank[r] = rank_row(col_bits[3*r +: 3]);
    end

    logic best_lo, mid_mid, worst_hi;

    // Rows ranked, then the three column extremes, then a final vote.
    assign best_lo  = or3(rank[0].lo, rank[1].lo, rank[2].lo);
    assign mid_mid  = maj3(rank[0].mid, rank[1].mid, rank[2].mid);
    assign worst_hi = and3(rank[0].hi, rank[1].hi, rank[2].hi);
    assign vote     = maj3(best_lo, mid_mid, worst_hi);
endmodule

// File: rtl/medmaj_therm_dec.sv
module medmaj_therm_dec
    import medmaj_pkg::*;
#(
    parameter int         SAMPLE_W = 4,
    parameter dec_style_e STYLE    = DEC_POPCOUNT,
    localparam int TW = 2 ** SAMPLE_W
) (
    input  logic [TW-1:0]       therm,
    output logic [SAMPLE_W-1:0] value
);
    if (STYLE == DEC_POPCOUNT) begin : g_count
        logic [SAMPLE_W:0] total;
        always_comb begin
            total = '0;
            for (int i = 0; i < TW; i++) begin
                total = total + (SAMPLE_W + 1)'(therm[i]);
            end
        end
        assign value = total[SAMPLE_W-1:0];
    end else begin : g_prio
        always_comb begin
            value = '0;
            for (int i = 0; i < TW - 1; i++) begin
                if (therm[i]) value = SAMPLE_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/median9_vote.sv
module median9_vote
    import medmaj_pkg::*;
#(
    parameter int         SAMPLE_W  = 4,
    parameter dec_style_e DEC_STYLE = DEC_POPCOUNT,
    localparam int TW  = 2 ** SAMPLE_W,
    localparam int WIN = TAPS * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WIN-1:0]      in_window,
    output logic                med_valid,
    output logic [SAMPLE_W-1:0] med_value,
    output logic [TW-1:0]       med_therm
);
    logic [WIN-1:0] win_q;
    logic           vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) win_q <= in_window;
        end
    end

    logic [TAPS-1:0][TW-1:0] enc;
    logic [TW-1:0][TAPS-1:0] cols;
    logic [TW-1:0]           votes;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        medmaj_therm_enc #(.SAMPLE_W(SAMPLE_W)) u_enc (
            .value (win_q[SAMPLE_W*k +: SAMPLE_W]),
            .therm (enc[k])
        );
        for (genvar j = 0; j < TW; j++) begin : g_route
            assign cols[j][k] = enc[k][j];
        end
    end

    for (genvar j = 0; j < TW; j++) begin : g_col
        medmaj_column_vote u_vote (
            .col_bits (cols[j]),
            .vote     (votes[j])
        );
    end

    medmaj_therm_dec #(.SAMPLE_W(SAMPLE_W), .STYLE(DEC_STYLE)) u_dec (
        .therm (votes),
        .value (med_value)
    );

    assign med_therm = votes;
    assign med_valid = vld_q;
endmodule

// File: rtl/median9_vote_chk.sv
module median9_vote_chk #(
    parameter int SAMPLE_W = 4,
    localparam int TW  = 2 ** SAMPLE_W,
    localparam int WIN = 9 * SAMPLE_W
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [WIN-1:0]      in_window,
    input logic                med_valid,
    input logic [SAMPLE_W-1:0] med_value,
    input logic [TW-1:0]       med_therm
);
    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> med_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!med_valid && $stable(med_value)));

    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (!med_valid && med_value == '0));

    assert_shape_R4: assert property (@(posedge clk) disable iff (rst)
        ((med_therm & (med_therm + TW'(1))) == '0) && !med_therm[TW-1]);

    assert_count_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(med_therm) == int'(med_value));

    logic unused_win;
    assign unused_win = ^in_window;
endmodule

bind median9_vote median9_vote_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_window (in_window),
    .med_valid (med_valid),
    .med_value (med_value),
    .med_therm (med_therm)
);

// File: tb/median9_vote_test.sv
`timescale 1ns/1ps
module median9_vote_test;
    localparam int W  = 4;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [35:0]   in_window = '0;
    logic          med_valid;
    logic [W-1:0]  med_value;
    logic [TW-1:0] med_therm;

    int checks = 0;
    int fails  = 0;
    bit model_on = 1'b0;

    always #2.5 clk = ~clk;

    median9_vote #(.SAMPLE_W(W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_window(in_window),
        .med_valid(med_valid), .med_value(med_value), .med_therm(med_therm)
    );

    function automatic int median_of(input logic [35:0] w);
        int a [9];
        for (int i = 0; i < 9; i++) a[i] = int'(w[4*i +: 4]);
        for (int i = 0; i < 9; i++)
            for (int k = 0; k < 8 - i; k++)
                if (a[k] > a[k+1]) begin
                    int t = a[k]; a[k] = a[k+1]; a[k+1] = t;
                end
        return a[4];
    endfunction

    function automatic logic [15:0] therm_of(input int v);
        logic [16:0] t;
        t = (17'd1 << v) - 17'd1;
        return t[15:0];
    endfunction

    function automatic logic [35:0] pack9(input int s0, s1, s2, s3, s4, s5, s6, s7, s8);
        logic [35:0] w;
        w = {4'(s8), 4'(s7), 4'(s6), 4'(s5), 4'(s4), 4'(s3), 4'(s2), 4'(s1), 4'(s0)};
        return w;
    endfunction

    // Behavioural reference: updated on each rising edge.
    bit exp_valid = 1'b0;
    int exp_value = 0;
    always @(posedge clk) begin
        if (rst) begin
            exp_valid <= 1'b0;
            exp_value <= 0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) exp_value <= median_of(in_window);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Wait to the next falling edge, then compare with the reference.
    task automatic cycle();
        @(negedge clk);
        if (model_on) begin
            chk(med_valid == exp_valid, "R6 valid vs model", int'(med_valid), int'(exp_valid));
            chk(int'(med_value) == exp_value, "R1 median vs model", int'(med_value), exp_value);
            chk(med_therm == therm_of(exp_value), "R2 therm vs model", int'(med_therm),
                int'(therm_of(exp_value)));
            chk($countones(med_therm) == int'(med_value), "R5 count of ones",
                $countones(med_therm), int'(med_value));
        end
    endtask

    task automatic push(input logic [35:0] w, input logic v);
        in_window = w;
        in_valid  = v;
        cycle();
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [35:0] w;
        @(negedge clk);
        rst = 1'b1;
        cycle();
        cycle();
        rst = 1'b0;
        cycle();
        // R8: reset state
        chk(med_valid == 1'b0, "R8 valid after reset", int'(med_valid), 0);
        chk(med_value == '0, "R8 value after reset", int'(med_value), 0);
        model_on = 1'b1;

        // R1 and R9: the same set in two orders
        push(pack9(2, 3, 4, 6, 7, 8, 10, 12, 15), 1'b1);
        chk(med_valid && med_value == 4'd7, "R1 ascending set", int'(med_value), 7);
        push(pack9(15, 6, 2, 12, 7, 3, 10, 4, 8), 1'b1);
        chk(med_valid && med_value == 4'd7, "R9 shuffled set", int'(med_value), 7);

        // R7: strobe low is ignored and the value is held
        push(pack9(15, 15, 15, 15, 15, 15, 15, 15, 15), 1'b0);
        chk(!med_valid, "R7 valid low when idle", int'(med_valid), 0);
        chk(med_value == 4'd7, "R7 value held", int'(med_value), 7);

        // R10 and R2: uniform windows
        push(pack9(0, 0, 0, 0, 0, 0, 0, 0, 0), 1'b1);
        chk(med_value == 4'd0 && med_therm == 16'h0000, "R10 all zero", int'(med_value), 0);
        push(pack9(15, 15, 15, 15, 15, 15, 15, 15, 15), 1'b1);
        chk(med_value == 4'd15 && med_therm == 16'h7FFF, "R10 all max", int'(med_therm), 'h7FFF);
        chk(med_therm[15] == 1'b0, "R4 top bit clear", int'(med_therm[15]), 0);
        push(pack9(8, 8, 8, 8, 8, 8, 8, 8, 8), 1'b1);
        chk(med_therm == 16'h00FF, "R2 code for 8", int'(med_therm), 'h00FF);
        push(pack9(2, 2, 9, 1, 0, 2, 14, 2, 3), 1'b1);
        chk(med_therm == 16'h0003, "R2 code for 2", int'(med_therm), 'h0003);
        push(pack9(1, 5, 5, 5, 9, 2, 5, 14, 0), 1'b1);
        chk(med_value == 4'd5, "R10 repeated middle", int'(med_value), 5);

        // R3: exhaustive vote on columns 0 and 14
        for (int col = 0; col < 15; col += 14) begin
            for (int m = 0; m < 512; m++) begin
                for (int k = 0; k < 9; k++) w[4*k +: 4] = m[k] ? 4'(col + 1) : 4'(col);
                push(w, 1'b1);
                chk(med_therm[col] == ($countones(m[8:0]) >= 5), "R3 column vote",
                    int'(med_therm[col]), int'($countones(m[8:0]) >= 5));
            end
        end

        // Random windows with gaps in the strobe
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < 9; k++) w[4*k +: 4] = 4'($urandom_range(0, 15));
            push(w, ($urandom_range(0, 3) != 0));
        end

        // R8: reset in mid stream
        push(pack9(9, 9, 9, 9, 9, 9, 9, 9, 9), 1'b1);
        rst = 1'b1;
        push(pack9(4, 4, 4, 4, 4, 4, 4, 4, 4), 1'b1);
        chk(!med_valid && med_value == '0, "R8 mid-stream reset", int'(med_value), 0);
        rst = 1'b0;
        push(pack9(4, 4, 4, 4, 4, 4, 4, 4, 4), 1'b1);
        chk(med_valid && med_value == 4'd4, "R6 after reset", int'(med_value), 4);
        in_valid = 1'b0;
        cycle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule